// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block is a serial master for a three-wire, select-gated bus, controlled through a small 16-bit register window. A host writes a left-justified word to the data register and then writes a command to the control register. The command names one of four slave selects and gives either a transmit bit count or a receive bit count. The block then toggles the serial clock and either shifts the word out, most significant bit first, or collects bits from the data-in line. It never does both in one command.

Each select has its own six-bit setting. The setting chooses the edge on which output bits change, the edge on which input bits are sampled, whether the select line is active high or active low, how many prescaler ticks make up one half of a serial clock period, and whether the block must see data-in low before it starts clocking. A separate prescaler supplies a one-cycle enable tick. Every serial clock transition happens on such a tick.

Register addresses are 0 for data, 1 for control and status, 2 for the settings of selects 0 and 1, and 3 for the settings of selects 2 and 3. Reads of unused high bits return zero.

Top module: `mwire_master`

## Requirements
- R1: After reset the serial clock is low, status reads as zero, and with all settings zero every select output is high (inactive).
- R2: A command with transmit count N (control bits 9:5, nonzero) produces exactly N serial clock rising edges. The bits driven are data register bits 15 down to 16-N, in that order.
- R3: A command with transmit count zero and receive count N (control bits 4:0) shifts in N bits. The last bit received ends in bit 0, and bits above N-1 read as zero.
- R4: A nonzero transmit count takes priority, and the receive count is then ignored: no receive-ready flag is raised. Counts above 16 act as 16.
- R5: Setting bit 1 = 0 makes output bits change on falling edges, so they are stable at rising edges. Bit 1 = 1 makes them change on rising edges, so they are stable at falling edges.
- R6: Setting bit 0 = 0 samples data-in on rising edges. Bit 0 = 1 samples it on falling edges.
- R7: Control bit 12 asserts the select chosen by bits 11:10. Setting bit 2 = 1 makes that select active high, and 0 makes it active low. Setting fields sit at register 2 bits 5:0 (select 0) and 11:6 (select 1), and register 3 bits 5:0 (select 2) and 11:6 (select 3).
- R8: While a select is asserted, a control write that asserts a different select is ignored entirely.
- R9: Status bit 14 is high while a command runs. Status bit 15 sets when a receive command ends and clears when the data register is read.
- R10: A control write while a command runs is ignored, including its start bit (bit 13).
- R11: With setting bit 5 = 1, no clock edge is produced until data-in is low. The command then completes normally.
- R12: A start with both counts zero produces no clock edge, and busy reads low again within two cycles.
- R13: Setting bits 4:3 give half-period lengths of 1, 2 and 4 ticks for codes 0, 1 and 2. Code 3 acts as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler enable; serial timing advances only on it |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data register read clears receive-ready) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| cs_o | output | 4 | Select lines, level per select setting |

## Verification
A table of transfers is run. It covers every select, both output-edge choices, both sampling choices, all three divider codes, a one-bit word, a full 16-bit word and an over-range count. A wrong edge choice shows up as a shifted or corrupted word. A wrong divider shows up as a wrong spacing between the last rising and falling edges. A misdecoded select shows up as the wrong line active. Directed cases cover the ready gate on data-in, a start with zero counts, a command written while busy, and a select change attempted without first deasserting.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int MW_DW     = 16;
    localparam int MW_CNT_W  = 5;
    localparam int MW_NSEL   = 4;
    localparam int MW_SEL_W  = 2;
    localparam int MW_CFG_W  = 6;
    localparam int MW_PAIR_W = 2 * MW_CFG_W;
    localparam int MW_ADDR_W = 2;
    localparam int MW_HALF_W = 3;

    // control/status bit positions
    localparam int CT_RDY    = 15;
    localparam int CT_BUSY   = 14;
    localparam int CT_GO     = 13;
    localparam int CT_CSEN   = 12;
    localparam int CT_SEL_LO = 10;
    localparam int CT_TX_LO  = 5;
    localparam int CT_RX_LO  = 0;

    localparam logic [MW_ADDR_W-1:0] A_DATA   = 2'd0;
    localparam logic [MW_ADDR_W-1:0] A_CTRL   = 2'd1;
    localparam logic [MW_ADDR_W-1:0] A_CFG_LO = 2'd2;
    localparam logic [MW_ADDR_W-1:0] A_CFG_HI = 2'd3;

    typedef struct packed {
        logic       rdy_chk;      // bit 5
        logic [1:0] div;          // bits 4:3
        logic       cs_hi;        // bit 2
        logic       launch_rise;  // bit 1
        logic       sample_fall;  // bit 0
    } sel_cfg_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_SHIFT} eng_state_t;

    function automatic logic [MW_CNT_W-1:0] clamp_bits(input logic [MW_CNT_W-1:0] n);
        return (n > MW_CNT_W'(MW_DW)) ? MW_CNT_W'(MW_DW) : n;
    endfunction

    function automatic logic [MW_HALF_W-1:0] half_len(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic sel_cfg_t cfg_of(input logic [MW_PAIR_W-1:0] lo,
                                        input logic [MW_PAIR_W-1:0] hi,
                                        input logic [MW_SEL_W-1:0]  s);
        logic [MW_PAIR_W-1:0] pair;
        pair = s[1] ? hi : lo;
        return s[0] ? sel_cfg_t'(pair[MW_PAIR_W-1:MW_CFG_W]) : sel_cfg_t'(pair[MW_CFG_W-1:0]);
    endfunction
endpackage

// File: rtl/mw_ctrl_regs.sv
module mw_ctrl_regs
    import mw_pkg::*;
#(
    parameter int DW  = MW_DW,
    parameter int CW  = MW_CNT_W,
    parameter int SW  = MW_SEL_W,
    parameter int PW  = MW_PAIR_W,
    parameter int AW  = MW_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic          rx_done,
    output logic          start,
    output logic          cs_en,
    output logic [SW-1:0] sel,
    output logic [CW-1:0] tx_cnt,
    output logic [CW-1:0] rx_cnt,
    output logic [PW-1:0] cfg_lo,
    output logic [PW-1:0] cfg_hi,
    output logic [DW-1:0] tx_word,
    output logic          rx_ready
);
    logic ctrl_wr, busy_eff, sel_clash, accept, rd_clr;

    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign busy_eff  = busy || start;
    assign sel_clash = cs_en && wdata[CT_CSEN] && (wdata[CT_SEL_LO +: SW] != sel);
    assign accept    = ctrl_wr && !busy_eff && !sel_clash;       // R8, R10
    assign rd_clr    = rd_en && (addr == A_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            start    <= 1'b0;
            cs_en    <= 1'b0;
            sel      <= '0;
            tx_cnt   <= '0;
            rx_cnt   <= '0;
            cfg_lo   <= '0;
            cfg_hi   <= '0;
            tx_word  <= '0;
            rx_ready <= 1'b0;
        end else begin
            start <= 1'b0;
            if (wr_en && addr == A_DATA)   tx_word <= wdata;
            if (wr_en && addr == A_CFG_LO) cfg_lo  <= wdata[PW-1:0];
            if (wr_en && addr == A_CFG_HI) cfg_hi  <= wdata[PW-1:0];
            if (accept) begin
                cs_en  <= wdata[CT_CSEN];
                sel    <= wdata[CT_SEL_LO +: SW];
                tx_cnt <= wdata[CT_TX_LO +: CW];
                rx_cnt <= wdata[CT_RX_LO +: CW];
                start  <= wdata[CT_GO];
            end
            if (rx_done)
                rx_ready <= 1'b1;
            else if (rd_clr || (accept && wdata[CT_GO]))
                rx_ready <= 1'b0;
        end
    end

    // R10: a start is only issued to an idle engine
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R9: a data read without a completing receive leaves the flag clear
    p_ready_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_DATA && !rx_done) |=> !rx_ready);
endmodule

// File: rtl/mw_shift_engine.sv
module mw_shift_engine
    import mw_pkg::*;
#(
    parameter int DW = MW_DW,
    parameter int CW = MW_CNT_W,
    parameter int HW = MW_HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] tx_bits,
    input  logic [CW-1:0] rx_bits,
    input  logic [DW-1:0] tx_word,
    input  sel_cfg_t      cfg,
    input  logic          tick,
    input  logic          sdi,
    output logic          busy,
    output logic          rx_done,
    output logic [DW-1:0] rx_word,
    output logic          sclk,
    output logic          sdo
);
    eng_state_t    st;
    logic          wr_mode, half_hi;
    logic          q_rdy, q_lr, q_sf;
    logic [1:0]    q_div;
    logic [CW-1:0] nbits, bitcnt, n_req;
    logic [HW-1:0] tcnt;
    logic [DW-1:0] tx_sh, rx_sh;
    logic          wr_req, half_end, unused_cfg;

    assign unused_cfg = cfg.cs_hi;
    assign wr_req     = (tx_bits != '0);
    assign n_req      = wr_req ? clamp_bits(tx_bits) : clamp_bits(rx_bits);   // R4
    assign half_end   = (tcnt == HW'(half_len(q_div) - 3'd1));              // R13
    assign busy       = (st != ENG_IDLE);
    assign rx_word    = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ENG_IDLE;
            wr_mode <= 1'b0;
            half_hi <= 1'b0;
            q_rdy   <= 1'b0;
            q_lr    <= 1'b0;
            q_sf    <= 1'b0;
            q_div   <= '0;
            nbits   <= '0;
            bitcnt  <= '0;
            tcnt    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk    <= 1'b0;
            sdo     <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    if (start && n_req != '0) begin                      // R12
                        st      <= ENG_WAIT;
                        wr_mode <= wr_req;
                        nbits   <= n_req;
                        q_rdy   <= cfg.rdy_chk;
                        q_lr    <= cfg.launch_rise;
                        q_sf    <= cfg.sample_fall;
                        q_div   <= cfg.div;
                        bitcnt  <= '0;
                        tcnt    <= '0;
                        half_hi <= 1'b0;
                        tx_sh   <= tx_word;
                        rx_sh   <= '0;
                    end
                end
                ENG_WAIT: begin
                    if (!q_rdy || !sdi) begin                            // R11
                        st <= ENG_SHIFT;
                        if (wr_mode && !q_lr) begin
                            sdo   <= tx_sh[DW-1];
                            tx_sh <= tx_sh << 1;
                        end
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        if (!half_end) begin
                            tcnt <= tcnt + 1'b1;
                        end else begin
                            tcnt <= '0;
                            if (!half_hi) begin
                                half_hi <= 1'b1;
                                sclk    <= 1'b1;
                                if (wr_mode && q_lr) begin               // R5
                                    sdo   <= tx_sh[DW-1];
                                    tx_sh <= tx_sh << 1;
                                end
                                if (!wr_mode && !q_sf)                   // R6
                                    rx_sh <= {rx_sh[DW-2:0], sdi};
                            end else begin
                                half_hi <= 1'b0;
                                sclk    <= 1'b0;
                                if (!wr_mode && q_sf)
                                    rx_sh <= {rx_sh[DW-2:0], sdi};
                                if (bitcnt == nbits - 1'b1) begin
                                    st      <= ENG_IDLE;
                                    rx_done <= !wr_mode;
                                end else begin
                                    bitcnt <= bitcnt + 1'b1;
                                    if (wr_mode && !q_lr) begin
                                        sdo   <= tx_sh[DW-1];
                                        tx_sh <= tx_sh << 1;
                                    end
                                end
                            end
                        end
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R13: the serial clock only moves on a prescaler tick
    p_sclk_on_tick_r13: assert property (@(posedge clk) disable iff (rst)
        (sclk != $past(sclk)) |-> $past(tick));
    // R11: no clock activity while waiting for data-in
    p_quiet_in_wait_r11: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_WAIT) |-> !sclk);
    // R4: the bit counter never runs past the clamped length
    p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_SHIFT) |-> (bitcnt < nbits && nbits <= CW'(DW)));
    // R9: receive completion coincides with return to idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (st == ENG_IDLE && !sclk));
endmodule

// File: rtl/mw_cs_drive.sv
module mw_cs_drive
    import mw_pkg::*;
#(
    parameter int NSEL = MW_NSEL,
    parameter int SW   = MW_SEL_W,
    parameter int PW   = MW_PAIR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_en,
    input  logic [SW-1:0]   sel,
    input  logic [PW-1:0]   cfg_lo,
    input  logic [PW-1:0]   cfg_hi,
    output logic [NSEL-1:0] cs_o
);
    logic [NSEL-1:0] active;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        sel_cfg_t c;
        logic     unused_fields;
        assign c             = cfg_of(cfg_lo, cfg_hi, SW'(i));
        assign unused_fields = ^{c.rdy_chk, c.div, c.launch_rise, c.sample_fall};
        assign active[i]     = cs_en && (sel == SW'(i));
        assign cs_o[i]       = active[i] ? c.cs_hi : ~c.cs_hi;          // R7
    end

    // R7: at most one select line sits at its active level
    p_one_select_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active));
endmodule

// File: rtl/mwire_master.sv
module mwire_master
    import mw_pkg::*;
#(
    parameter int DW   = MW_DW,
    parameter int NSEL = MW_NSEL,
    parameter int AW   = MW_ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            sdi,
    output logic            sclk,
    output logic            sdo,
    output logic [NSEL-1:0] cs_o
);
    localparam int CW = MW_CNT_W;
    localparam int SW = MW_SEL_W;
    localparam int PW = MW_PAIR_W;

    logic          start, cs_en, rx_ready, eng_busy, rx_done, busy_any;
    logic [SW-1:0] sel;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [PW-1:0] cfg_lo, cfg_hi;
    logic [DW-1:0] tx_word, rx_word;
    sel_cfg_t      cur_cfg;

    assign cur_cfg  = cfg_of(cfg_lo, cfg_hi, sel);
    assign busy_any = eng_busy || start;

    mw_ctrl_regs #(.DW(DW), .CW(CW), .SW(SW), .PW(PW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .busy(eng_busy), .rx_done(rx_done), .start(start),
        .cs_en(cs_en), .sel(sel), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .tx_word(tx_word), .rx_ready(rx_ready)
    );

    mw_shift_engine #(.DW(DW), .CW(CW)) u_eng (
        .clk(clk), .rst(rst), .start(start), .tx_bits(tx_cnt), .rx_bits(rx_cnt),
        .tx_word(tx_word), .cfg(cur_cfg), .tick(tick), .sdi(sdi), .busy(eng_busy),
        .rx_done(rx_done), .rx_word(rx_word), .sclk(sclk), .sdo(sdo)
    );

    mw_cs_drive #(.NSEL(NSEL), .SW(SW), .PW(PW)) u_cs (
        .clk(clk), .rst(rst), .cs_en(cs_en), .sel(sel),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cs_o(cs_o)
    );

    always_comb begin
        case (bus_addr)
            A_DATA:   bus_rdata = rx_word;
            A_CTRL:   bus_rdata = {rx_ready, busy_any, 1'b0, cs_en, sel, tx_cnt, rx_cnt};
            A_CFG_LO: bus_rdata = DW'(cfg_lo);
            default:  bus_rdata = DW'(cfg_hi);
        endcase
    end
endmodule

// File: tb/mwire_master_bench.sv
`timescale 1ns/1ps
module mwire_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {sel[33:32], cfg[31:26], txn[25:21], rxn[20:16], word[15:0]}
    localparam logic [33:0] VEC [0:NVEC-1] = '{
        {2'd0, 6'h00, 5'd8,  5'd0, 16'hA500},
        {2'd1, 6'h02, 5'd12, 5'd0, 16'hBEE0},
        {2'd2, 6'h08, 5'd0,  5'd8, 16'h005A},
        {2'd3, 6'h01, 5'd0,  5'd16,16'hC3A5},
        {2'd0, 6'h10, 5'd20, 5'd5, 16'h8001},
        {2'd1, 6'h05, 5'd0,  5'd3, 16'h0005},
        {2'd2, 6'h03, 5'd1,  5'd0, 16'h8000}
    };

    logic clk = 0, rst = 1, tick = 0;
    logic [1:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic sdi, sclk, sdo;
    logic [3:0] cs_o;

    int checks = 0, errors = 0, cyc = 0;
    int rises = 0, falls = 0, t_rise = 0, t_fall = 0;
    logic prev_sclk = 0;
    logic [15:0] cap = 0;
    logic cap_on_rise = 1, present_on_rise = 0, slave_en = 1, force_sdi = 0, slave_sdi;
    logic [15:0] slave_word = 0;
    int slave_n = 1, base_r = 0, base_f = 0;
    logic [5:0] cfg_model [0:3] = '{6'h0, 6'h0, 6'h0, 6'h0};
    logic done = 0;

    mwire_master u_mwire_master (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sdi(sdi), .sclk(sclk), .sdo(sdo), .cs_o(cs_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever begin @(negedge clk); tick = ~tick; end

    // slave model: next bit presented on the edge opposite the sampling edge
    always_comb begin
        int k, idx;
        k = present_on_rise ? (rises - base_r - 1) : (falls - base_f);
        idx = slave_n - 1 - k;
        slave_sdi = (idx >= 0 && idx < 16) ? slave_word[idx] : 1'b0;
    end
    assign sdi = slave_en ? slave_sdi : force_sdi;

    initial forever begin
        @(negedge clk);
        cyc++;
        if (sclk && !prev_sclk) begin
            rises++; t_rise = cyc;
            if (cap_on_rise) cap = {cap[14:0], sdo};
        end
        if (!sclk && prev_sclk) begin
            falls++; t_fall = cyc;
            if (!cap_on_rise) cap = {cap[14:0], sdo};
        end
        prev_sclk = sclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic [5:0] c);
        cfg_model[s] = c;
        cfg_model[s ^ 2'd1] = 6'h0;
        wr(s[1] ? 2'd3 : 2'd2, s[0] ? {4'h0, c, 6'h0} : {4'h0, 6'h0, c});
    endtask

    function automatic logic [3:0] exp_cs(input logic en, input logic [1:0] s);
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = (en && s == 2'(i)) ? cfg_model[i][2] : ~cfg_model[i][2];
        return r;
    endfunction

    task automatic wait_idle();
        logic [15:0] st;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4000; i++) begin
            rd(2'd1, st);
            if (!st[14]) break;
        end
    endtask

    function automatic int half_ticks(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    initial begin
        repeat (CLK_PERIOD * 150000) begin
            #1;
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] st, dv;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 cs idle", 32'(cs_o), 32'hF);
        chk("R1 sclk low", 32'(sclk), 0);
        rd(2'd1, st);
        chk("R1 status", 32'(st), 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] s; logic [5:0] c; logic [4:0] tn, rn; logic [15:0] w;
            int n; logic is_wr; logic [31:0] mask;
            {s, c, tn, rn, w} = VEC[v];
            is_wr = (tn != 0);
            n = is_wr ? ((tn > 16) ? 16 : int'(tn)) : ((rn > 16) ? 16 : int'(rn));
            mask = (32'h1 << n) - 1;
            wr(2'd1, 16'h0);
            set_cfg(s, c);
            if (is_wr) wr(2'd0, w);
            cap_on_rise = !c[1];
            present_on_rise = c[0];
            slave_word = w; slave_n = n; slave_en = 1;
            base_r = rises; base_f = falls;
            wr(2'd1, {2'b00, 1'b1, 1'b1, s, tn, rn});
            chk("R7 select level", 32'(cs_o), 32'(exp_cs(1'b1, s)));
            wait_idle();
            chk(is_wr ? "R2 rising edge count" : "R3 rising edge count",
                32'(rises - base_r), 32'(n));
            chk("R13 half period", 32'(t_fall - t_rise), 32'(2 * half_ticks(c[4:3])));
            if (is_wr) begin
                chk(c[1] ? "R5 rise-launch word" : "R2 fall-launch word",
                    32'(cap) & mask, 32'(w >> (16 - n)));
                rd(2'd1, st);
                chk("R4 no ready on transmit", 32'(st[15]), 0);
            end else begin
                rd(2'd1, st);
                chk("R9 ready set", 32'(st[15]), 1);
                rd(2'd0, dv);
                chk(c[0] ? "R6 fall-sample word" : "R3 rise-sample word",
                    32'(dv), 32'(w) & mask);
                rd(2'd1, st);
                chk("R9 ready cleared", 32'(st[15]), 0);
            end
        end

        // R8: switching select while one is asserted is ignored
        wr(2'd1, 16'h0);
        set_cfg(2'd0, 6'h00);
        wr(2'd1, {4'b0001, 2'd0, 10'd0});
        wr(2'd1, {4'b0001, 2'd2, 10'd0});
        @(negedge clk);
        chk("R8 old select kept", 32'(cs_o), 32'(exp_cs(1'b1, 2'd0)));
        rd(2'd1, st);
        chk("R8 sel field kept", 32'(st[11:10]), 0);
        wr(2'd1, 16'h0);
        wr(2'd1, {4'b0001, 2'd2, 10'd0});
        @(negedge clk);
        chk("R8 switch after deassert", 32'(cs_o), 32'(exp_cs(1'b1, 2'd2)));

        // R10: command written while busy is ignored
        wr(2'd1, 16'h0);
        set_cfg(2'd0, 6'h10);
        cap_on_rise = 1; present_on_rise = 0;
        slave_word = 16'h1234; slave_n = 16; slave_en = 1;
        base_r = rises; base_f = falls;
        wr(2'd1, {4'b0011, 2'd0, 5'd0, 5'd16});
        repeat (4) @(negedge clk);
        wr(2'd1, {4'b0011, 2'd0, 5'd3, 5'd2});
        rd(2'd1, st);
        chk("R10 fields kept", 32'(st[9:0]), 32'({5'd0, 5'd16}));
        chk("R9 busy while running", 32'(st[14]), 1);
        wait_idle();
        chk("R10 edge count", 32'(rises - base_r), 16);
        rd(2'd0, dv);
        chk("R3 read word", 32'(dv), 32'h1234);

        // R12: both counts zero
        wr(2'd1, 16'h0);
        base_r = rises;
        wr(2'd1, {4'b0011, 2'd0, 10'd0});
        repeat (2) @(negedge clk);
        rd(2'd1, st);
        chk("R12 busy low", 32'(st[14]), 0);
        repeat (10) @(negedge clk);
        chk("R12 no clock", 32'(rises - base_r), 0);

        // R11: ready gate on data-in
        wr(2'd1, 16'h0);
        set_cfg(2'd0, 6'h20);
        wr(2'd0, 16'hF000);
        slave_en = 0; force_sdi = 1; cap_on_rise = 1;
        base_r = rises;
        wr(2'd1, {4'b0011, 2'd0, 5'd4, 5'd0});
        repeat (20) @(negedge clk);
        chk("R11 held off", 32'(rises - base_r), 0);
        rd(2'd1, st);
        chk("R11 busy while held", 32'(st[14]), 1);
        force_sdi = 0;
        wait_idle();
        chk("R11 edges after release", 32'(rises - base_r), 4);
        chk("R11 word after release", 32'(cap[3:0]), 32'hF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule